// File: doc/BRIEF.md
# Packed Add-Subtract and Min-Max ALU

This block is a single-stage packed arithmetic unit for a DSP datapath. It takes two 32-bit operands and an operation code. It returns a 64-bit result one clock later, together with a valid flag. The add-subtract operations produce the sum and the difference of the same operand pair in one pass: the sum goes in the low word and the difference in the high word. Each of these operations treats the operands either as full 32-bit words or as two independent 16-bit lanes, and each can either wrap or saturate with signed limits.

The same stage also provides four other functions:
- a dual 16-bit signed minimum and maximum;
- an unpack that widens two bytes of operand A into two 16-bit lanes;
- a saturating pack that narrows four signed 16-bit lanes into four unsigned bytes;
- a reserved code that returns zero.

Instruction decode and the register file sit outside this block. The result register loads only when an operation is issued.

Top module: `pkd_addsub_alu`

## Requirements
- R1: While rst_n is low, vld_o is 0 and res_o is all zeros.
- R2: vld_o equals vld_i of the previous cycle, and res_o is loaded only in a cycle where vld_i was high; otherwise res_o holds its value.
- R3: Op code 0 gives res_o[31:0] = A+B and res_o[63:32] = A-B, both modulo 2^32; mod_i has no effect on this op.
- R4: Op code 1 gives the same word sum and difference, each clamped to signed limits 0x7FFFFFFF / 0x80000000 on overflow.
- R5: Op code 2 performs wrapping add and subtract on lanes [31:16] and [15:0] independently, with no carry or borrow crossing bit 15/16; the low word holds the lane sums and the high word holds the lane differences.
- R6: Op code 3 is the lane form of R5 with each lane clamped to signed 0x7FFF / 0x8000.
- R7: Op code 4 compares each 16-bit lane as signed: res_o[31:0] holds the lane minima and res_o[63:32] holds the lane maxima.
- R8: Op code 5 unpacks bytes of A. mod_i[1]=1 selects A[31:24],A[23:16]; mod_i[1]=0 selects A[15:8],A[7:0]. mod_i[0]=1 sign-extends each byte to 16 bits; mod_i[0]=0 zero-extends it. The higher byte goes to res_o[31:16] and the lower byte to res_o[15:0]. res_o[63:32] is zero.
- R9: Op code 6 packs {A[31:16],A[15:0],B[31:16],B[15:0]} into res_o[31:24],[23:16],[15:8],[7:0]. Each signed lane is clamped: a negative value gives 0x00 and a value above 255 gives 0xFF. res_o[63:32] is zero.
- R10: Op code 7 returns an all-zero result with vld_o set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code (0..7) |
| mod_i | input | 2 | Unpack byte select and extension mode |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| vld_o | output | 1 | Result valid |
| res_o | output | 64 | Result: low word and high word |

## Verification
Every function writes the result register directly, so a wrong clamp, lane split or extension shows up at res_o in the cycle after the operation is issued. Nothing is hidden in deeper state. A carry leaking across the lane boundary, or saturation applied on the wrong side, corrupts exactly one lane, and the vectors are chosen to sit on those boundaries. A result register that loads on an idle cycle shows up in the next idle cycle, as a changed value on res_o while vld_o is low.

// File: rtl/pkd_addsub_alu.sv
module pkd_addsub_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vld_i,
  input  logic [2:0]  op_i,
  input  logic [1:0]  mod_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  output logic        vld_o,
  output logic [63:0] res_o
);

  function automatic logic [15:0] clamp16(input logic [16:0] s);
    if (s[16] != s[15]) return s[16] ? 16'h8000 : 16'h7FFF;
    return s[15:0];
  endfunction

  function automatic logic [31:0] clamp32(input logic [32:0] s);
    if (s[32] != s[31]) return s[32] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    return s[31:0];
  endfunction

  function automatic logic [7:0] to_u8(input logic [15:0] x);
    if (x[15]) return 8'h00;
    if (x[14:8] != 7'd0) return 8'hFF;
    return x[7:0];
  endfunction

  function automatic logic [15:0] widen(input logic [7:0] x, input logic sx);
    return {{8{sx & x[7]}}, x};
  endfunction

  logic [32:0] wsum, wdif;
  logic [16:0] hsum, hdif, lsum, ldif;
  logic        hlt, llt;
  logic [15:0] bsel_hi, bsel_lo;
  logic [63:0] nxt;

  assign wsum = {a_i[31], a_i} + {b_i[31], b_i};
  assign wdif = {a_i[31], a_i} - {b_i[31], b_i};
  assign hsum = {a_i[31], a_i[31:16]} + {b_i[31], b_i[31:16]};
  assign hdif = {a_i[31], a_i[31:16]} - {b_i[31], b_i[31:16]};
  assign lsum = {a_i[15], a_i[15:0]} + {b_i[15], b_i[15:0]};
  assign ldif = {a_i[15], a_i[15:0]} - {b_i[15], b_i[15:0]};
  assign hlt  = $signed(a_i[31:16]) < $signed(b_i[31:16]);
  assign llt  = $signed(a_i[15:0]) < $signed(b_i[15:0]);
  assign bsel_hi = widen(mod_i[1] ? a_i[31:24] : a_i[15:8], mod_i[0]);
  assign bsel_lo = widen(mod_i[1] ? a_i[23:16] : a_i[7:0], mod_i[0]);

  always_comb begin
    case (op_i)
      3'd0: nxt = {wdif[31:0], wsum[31:0]};
      3'd1: nxt = {clamp32(wdif), clamp32(wsum)};
      3'd2: nxt = {hdif[15:0], ldif[15:0], hsum[15:0], lsum[15:0]};
      3'd3: nxt = {clamp16(hdif), clamp16(ldif), clamp16(hsum), clamp16(lsum)};
      3'd4: nxt = {hlt ? b_i[31:16] : a_i[31:16], llt ? b_i[15:0] : a_i[15:0],
                   hlt ? a_i[31:16] : b_i[31:16], llt ? a_i[15:0] : b_i[15:0]};
      3'd5: nxt = {32'd0, bsel_hi, bsel_lo};
      3'd6: nxt = {32'd0, to_u8(a_i[31:16]), to_u8(a_i[15:0]),
                   to_u8(b_i[31:16]), to_u8(b_i[15:0])};
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= nxt;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (!vld_o && res_o == 64'd0));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) vld_i |=> vld_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> (!vld_o && $stable(res_o)));

  // R3
  sum_dif_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 3'd0) |=> ((res_o[31:0] + res_o[63:32]) == {$past(a_i[30:0]), 1'b0}));

  // R7
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 3'd4) |=> ($signed(res_o[31:16]) <= $signed(res_o[63:48]) &&
                                 $signed(res_o[15:0]) <= $signed(res_o[47:32])));

  // R9
  pack_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 3'd6) |=> (res_o[63:32] == 32'd0));

endmodule

// File: tb/pkd_addsub_alu_tb.sv
`timescale 1ns/1ps
module pkd_addsub_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  mod_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        vld_o;
  logic [63:0] res_o;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  pkd_addsub_alu dut_i (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
    .mod_i(mod_i), .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o));

  // fields: req[136:133] op[132:130] mod[129:128] a[127:96] b[95:64] exp[63:0]
  localparam int NV = 18;
  localparam logic [136:0] VEC [NV] = '{
    {4'd3, 3'd0, 2'd3, 32'h0000_0005, 32'h0000_0003, 64'h00000002_00000008}, // R3 mod ignored
    {4'd3, 3'd0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 64'hFFFFFFFE_00000000}, // R3 wrap
    {4'd4, 3'd1, 2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 64'h7FFFFFFE_7FFFFFFF}, // R4 positive clamp
    {4'd4, 3'd1, 2'd0, 32'h8000_0000, 32'h0000_0001, 64'h80000000_80000001}, // R4 negative clamp
    {4'd4, 3'd1, 2'd0, 32'h8000_0000, 32'h8000_0000, 64'h00000000_80000000}, // R4
    {4'd5, 3'd2, 2'd0, 32'h0001_FFFF, 32'h0001_0001, 64'h0000FFFE_00020000}, // R5 no carry across
    {4'd5, 3'd2, 2'd0, 32'h7FFF_8000, 32'h0001_0001, 64'h7FFE7FFF_80008001}, // R5
    {4'd6, 3'd3, 2'd0, 32'h7FFF_8000, 32'h0001_0001, 64'h7FFE8000_7FFF8001}, // R6
    {4'd6, 3'd3, 2'd0, 32'h8000_7FFF, 32'h7FFF_8000, 64'h80007FFF_FFFFFFFF}, // R6
    {4'd7, 3'd4, 2'd0, 32'hFFFF_0005, 32'h0001_0003, 64'h00010005_FFFF0003}, // R7
    {4'd7, 3'd4, 2'd0, 32'h8000_7FFF, 32'h7FFF_8000, 64'h7FFF7FFF_80008000}, // R7 extremes
    {4'd8, 3'd5, 2'd0, 32'h1234_5680, 32'h0,         64'h00000000_00560080}, // R8 zero low
    {4'd8, 3'd5, 2'd1, 32'h1234_5680, 32'h0,         64'h00000000_0056FF80}, // R8 sign low
    {4'd8, 3'd5, 2'd2, 32'h1234_5680, 32'h0,         64'h00000000_00120034}, // R8 zero high
    {4'd8, 3'd5, 2'd3, 32'h80FF_1234, 32'h0,         64'h00000000_FF80FFFF}, // R8 sign high
    {4'd9, 3'd6, 2'd0, 32'h0100_FF85, 32'h007F_0000, 64'h00000000_FF007F00}, // R9
    {4'd9, 3'd6, 2'd0, 32'h00FF_0080, 32'h7FFF_8000, 64'h00000000_FF80FF00}, // R9
    {4'd10,3'd7, 2'd0, 32'hDEAD_BEEF, 32'h1234_5678, 64'h0}                  // R10
  };

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {vld_o, res_o}, {1'b0, 64'd0});
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      vld_i = 1'b1;
      op_i  = VEC[i][132:130];
      mod_i = VEC[i][129:128];
      a_i   = VEC[i][127:96];
      b_i   = VEC[i][95:64];
      @(negedge clk);
      vld_i = 1'b0;
      check($sformatf("R%0d vec %0d", VEC[i][136:133], i), {vld_o, res_o}, {1'b1, VEC[i][63:0]});
    end
    // R2: idle cycle leaves result untouched and drops valid
    op_i = 3'd0; a_i = 32'h1111_1111; b_i = 32'h2222_2222;
    @(negedge clk);
    check("R2 idle hold", {vld_o, res_o}, {1'b0, 64'd0});
    vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
    check("R2 issue", {vld_o, res_o}, {1'b1, 64'hEEEEEEEF_33333333});
    @(negedge clk);
    check("R2 hold after issue", {vld_o, res_o}, {1'b0, 64'hEEEEEEEF_33333333});
    // R1: asynchronous reset clears a loaded result
    rst_n = 1'b0;
    #1;
    check("R1 async", {vld_o, res_o}, {1'b0, 64'd0});
    @(negedge clk);
    rst_n = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule